// File: doc/BRIEF.md
# I2C Control Register and Bus-Condition Sequencer

This block holds the byte-wide control register of an I2C interface and turns its command bits into line activity on open-drain SCL and SDA. The CPU writes the register to enable the interface, ask for a START (a repeated START if the interface is already bus master), ask for a STOP, or ask for both. In the last case a master sends a STOP and then a START. When the interface is a slave, a STOP request only resets the interface internally and drives nothing on the bus. The block also answers the acknowledge slot that a byte engine announces. It pulls SDA low for ACK or leaves it released for NACK, based on the acknowledge-enable bit and on the receive context the byte engine reports.

The interrupt flag is set by the hardware when a START finishes, when a STOP-then-START finishes, and when an acknowledge slot finishes. While the flag is set, SCL is held low, so the bus waits for software. Software clears the flag by writing 0 to it. The STOP bit clears itself when its request has been served. Every line step waits for a bit-time tick. A step that releases SCL also waits until the synchronised SCL input reads high, which lets a slave stretch the clock.

Top module: `i2c_ctl_seq`

## Requirements
- R1: After reset the control register reads 0x00, the interrupt flag is 0, and both `sda_oe` and `scl_oe` are 0 (lines released).
- R2: Readback layout is bit6 enable, bit5 start request, bit4 stop request, bit3 interrupt flag, bit2 acknowledge enable, bit0 clock-select. Bits 7 and 1 always read 0 and ignore writes. Enable, acknowledge enable and clock-select hold the value written.
- R3: Only the hardware sets the interrupt flag. A CPU write of 0 clears it and a CPU write of 1 leaves it unchanged. `irq` equals the flag.
- R4: A start request while not bus master produces the line steps {sda_oe,scl_oe} = 10, 11, 01 and then sets the interrupt flag.
- R5: A start request while bus master (repeated START) produces 01, 00, 10, 11, 01 and then sets the interrupt flag.
- R6: A stop request while bus master produces 11, 10, 00. It then clears the stop bit and leaves the interrupt flag at 0.
- R7: Start and stop requested together while bus master produce 11, 10, 00, 10, 11, 01. The stop bit is then cleared, the interrupt flag is set, and the start bit keeps its value.
- R8: A stop request while slave drives no line and clears the stop bit. If the start bit is also set, a START (10, 11, 01) follows.
- R9: An acknowledge-slot request with acknowledge enable 1 and at least one of own-address match, general-call match with its enable, master-receiver data, or addressed-slave-receiver data produces 11, 10, 11, 01. SDA is low for the whole slot, and the interrupt flag is then set.
- R10: Any other acknowledge-slot request produces 01, 00, 01. SDA stays released (NACK), and the interrupt flag is then set.
- R11: While enabled with the interrupt flag at 1, SCL is held low and no command or acknowledge request is started.
- R12: With enable 0 both lines are released, the sequencer stays idle, and commands and acknowledge requests have no effect.
- R13: A step that has released SCL does not move on until the synchronised `scl_in` is high (clock stretching).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register readback |
| bus_master | input | 1 | 1 when the interface currently owns the bus as master |
| own_addr_hit | input | 1 | Own slave address has been received |
| gcall_hit | input | 1 | General call address has been received |
| gcall_en | input | 1 | General call recognition enabled |
| mrx_data | input | 1 | Data byte received in master receiver mode |
| srx_data | input | 1 | Data byte received in addressed slave receiver mode |
| ack_slot | input | 1 | One-cycle request to run an acknowledge slot |
| bit_tick | input | 1 | Bit-time tick that paces every line step |
| scl_in | input | 1 | Sampled SCL line level |
| sda_oe | output | 1 | Drive SDA low when 1 |
| scl_oe | output | 1 | Drive SCL low when 1 |
| irq | output | 1 | Interrupt flag |

## Verification
The bench builds the block with a three-stage SCL synchroniser, so every wait for SCL high spans several cycles before the next tick counts. The bench models SCL as a wired-AND of the block's own drive and a stretch control it owns, which makes the clock-stretching hold observable. Ticks come every four cycles. A monitor records each change of the two drive enables, so each command is checked as an ordered list of line steps and not at fixed cycle counts. The acknowledge decision is swept over all 64 combinations of acknowledge enable and the five context inputs, with the expected ACK or NACK computed in the bench.

// File: rtl/i2cc_pkg.sv
package i2cc_pkg;

  localparam int CTL_W  = 8;
  localparam int B_EN   = 6;
  localparam int B_STA  = 5;
  localparam int B_STO  = 4;
  localparam int B_SI   = 3;
  localparam int B_AA   = 2;
  localparam int B_CSEL = 0;

  typedef enum logic [3:0] {
    ST_REST,
    ST_SETUP,
    ST_RISE,
    ST_FALL,
    ST_LOCK,
    ST_PDN,
    ST_PUP,
    ST_PREL,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_ACK_END
  } seq_st_t;

  // Acknowledge decision: drive ACK only when enabled and a receive context applies.
  function automatic logic ack_decide(input logic aa, input logic own, input logic gc,
                                      input logic gc_en, input logic mrx, input logic srx);
    return aa & (own | (gc & gc_en) | mrx | srx);
  endfunction

  // Line drive per state, returned as {sda_oe, scl_oe}.
  function automatic logic [1:0] line_drive(input seq_st_t st, input logic ack, input logic si);
    logic [1:0] d;
    case (st)
      ST_REST:    d = {1'b0, si};
      ST_SETUP:   d = 2'b01;
      ST_RISE:    d = 2'b00;
      ST_FALL:    d = 2'b10;
      ST_LOCK:    d = 2'b11;
      ST_PDN:     d = 2'b11;
      ST_PUP:     d = 2'b10;
      ST_PREL:    d = 2'b00;
      ST_ACK_LO:  d = {ack, 1'b1};
      ST_ACK_HI:  d = {ack, 1'b0};
      ST_ACK_END: d = {ack, 1'b1};
      default:    d = 2'b00;
    endcase
    return d;
  endfunction

  // States in which SCL is released and must be seen high before moving on.
  function automatic logic waits_scl(input seq_st_t st);
    return (st == ST_RISE) || (st == ST_PUP) || (st == ST_ACK_HI);
  endfunction

  function automatic logic [CTL_W-1:0] pack_ctl(input logic en, input logic sta, input logic sto,
                                                input logic si, input logic aa, input logic csel);
    logic [CTL_W-1:0] r;
    r         = '0;
    r[B_EN]   = en;
    r[B_STA]  = sta;
    r[B_STO]  = sto;
    r[B_SI]   = si;
    r[B_AA]   = aa;
    r[B_CSEL] = csel;
    return r;
  endfunction

endpackage

// File: rtl/i2cc_sync.sv
module i2cc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff[0] <= 1'b1;
    else        ff[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff[i] <= 1'b1;
        else        ff[i] <= ff[i-1];
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/i2cc_regs.sv
module i2cc_regs
  import i2cc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             set_si,
  input  logic             clr_sto,
  output logic             en,
  output logic             sta,
  output logic             sto,
  output logic             si,
  output logic             aa,
  output logic [CTL_W-1:0] rd_data
);
  logic csel;
  logic unused_rsv;

  assign unused_rsv = ^{wr_data[7], wr_data[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      sta  <= 1'b0;
      aa   <= 1'b0;
      csel <= 1'b0;
    end else if (wr_en) begin
      en   <= wr_data[B_EN];
      sta  <= wr_data[B_STA];
      aa   <= wr_data[B_AA];
      csel <= wr_data[B_CSEL];
    end
  end

  // Stop bit: a CPU write takes priority over the hardware clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sto <= 1'b0;
    else if (wr_en)   sto <= wr_data[B_STO];
    else if (clr_sto) sto <= 1'b0;
  end

  // Interrupt flag: a hardware set takes priority; the CPU can only clear it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         si <= 1'b0;
    else if (set_si)                    si <= 1'b1;
    else if (wr_en && !wr_data[B_SI])   si <= 1'b0;
  end

  assign rd_data = pack_ctl(en, sta, sto, si, aa, csel);
endmodule

// File: rtl/i2cc_seq.sv
module i2cc_seq
  import i2cc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sta,
  input  logic sto,
  input  logic si,
  input  logic bus_master,
  input  logic tick,
  input  logic scl_hi,
  input  logic ack_slot,
  input  logic ack_bit,
  output logic sda_oe,
  output logic scl_oe,
  output logic set_si,
  output logic clr_sto,
  output logic ack_take,
  output logic busy
);
  seq_st_t st, st_nxt;
  logic    ack_q, ack_nxt;
  logic    adv;

  assign adv = tick && (!waits_scl(st) || scl_hi);

  always_comb begin
    st_nxt   = st;
    ack_nxt  = ack_q;
    set_si   = 1'b0;
    clr_sto  = 1'b0;
    ack_take = 1'b0;
    case (st)
      ST_REST: begin
        if (!si) begin
          if (sto) begin
            if (bus_master) st_nxt = ST_PDN;
            else            clr_sto = 1'b1;   // internal stop only
          end else if (sta) begin
            st_nxt = bus_master ? ST_SETUP : ST_RISE;
          end else if (ack_slot) begin
            st_nxt   = ST_ACK_LO;
            ack_nxt  = ack_bit;
            ack_take = 1'b1;
          end
        end
      end
      ST_SETUP:   if (adv) st_nxt = ST_RISE;
      ST_RISE:    if (adv) st_nxt = ST_FALL;
      ST_FALL:    if (adv) st_nxt = ST_LOCK;
      ST_LOCK: begin
        if (adv) begin
          st_nxt = ST_REST;
          set_si = 1'b1;
        end
      end
      ST_PDN:     if (adv) st_nxt = ST_PUP;
      ST_PUP:     if (adv) st_nxt = ST_PREL;
      ST_PREL: begin
        if (adv) begin
          clr_sto = 1'b1;
          st_nxt  = sta ? ST_RISE : ST_REST;
        end
      end
      ST_ACK_LO:  if (adv) st_nxt = ST_ACK_HI;
      ST_ACK_HI:  if (adv) st_nxt = ST_ACK_END;
      ST_ACK_END: begin
        if (adv) begin
          st_nxt = ST_REST;
          set_si = 1'b1;
        end
      end
      default:    st_nxt = ST_REST;
    endcase
    if (!en) begin
      st_nxt   = ST_REST;
      ack_nxt  = 1'b0;
      set_si   = 1'b0;
      clr_sto  = 1'b0;
      ack_take = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_REST;
      ack_q <= 1'b0;
    end else begin
      st    <= st_nxt;
      ack_q <= ack_nxt;
    end
  end

  logic [1:0] drv;
  assign drv    = en ? line_drive(st, ack_q, si) : 2'b00;
  assign sda_oe = drv[1];
  assign scl_oe = drv[0];
  assign busy   = (st != ST_REST);
endmodule

// File: rtl/i2c_ctl_seq.sv
module i2c_ctl_seq
  import i2cc_pkg::*;
#(
  parameter int SCL_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] rd_data,
  input  logic             bus_master,
  input  logic             own_addr_hit,
  input  logic             gcall_hit,
  input  logic             gcall_en,
  input  logic             mrx_data,
  input  logic             srx_data,
  input  logic             ack_slot,
  input  logic             bit_tick,
  input  logic             scl_in,
  output logic             sda_oe,
  output logic             scl_oe,
  output logic             irq
);
  logic en, sta, sto, si, aa;
  logic seq_done, stop_done, ack_take, busy;
  logic scl_hi, ack_bit;

  assign ack_bit = ack_decide(aa, own_addr_hit, gcall_hit, gcall_en, mrx_data, srx_data);

  i2cc_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .set_si  (seq_done),
    .clr_sto (stop_done),
    .en      (en),
    .sta     (sta),
    .sto     (sto),
    .si      (si),
    .aa      (aa),
    .rd_data (rd_data)
  );

  i2cc_sync #(.STAGES(SCL_SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (scl_in),
    .q     (scl_hi)
  );

  i2cc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .sta        (sta),
    .sto        (sto),
    .si         (si),
    .bus_master (bus_master),
    .tick       (bit_tick),
    .scl_hi     (scl_hi),
    .ack_slot   (ack_slot),
    .ack_bit    (ack_bit),
    .sda_oe     (sda_oe),
    .scl_oe     (scl_oe),
    .set_si     (seq_done),
    .clr_sto    (stop_done),
    .ack_take   (ack_take),
    .busy       (busy)
  );

  assign irq = si;
endmodule

// File: rtl/i2c_ctl_seq_chk.sv
module i2c_ctl_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic en,
  input logic sto,
  input logic si,
  input logic aa,
  input logic own_addr_hit,
  input logic gcall_hit,
  input logic gcall_en,
  input logic mrx_data,
  input logic srx_data,
  input logic ack_take,
  input logic seq_done,
  input logic stop_done,
  input logic busy,
  input logic sda_oe,
  input logic scl_oe
);
  logic ctx_hit;
  assign ctx_hit = own_addr_hit | (gcall_hit & gcall_en) | mrx_data | srx_data;

  AST_SI_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si) |-> $past(seq_done)); // R3

  AST_STO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sto) && !$past(wr_en) |-> $past(stop_done)); // R6

  AST_SCL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    en && si |-> scl_oe); // R11

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy); // R12

  AST_ACK_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take && !wr_en && aa && ctx_hit |=> sda_oe); // R9

  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take && !aa |=> !sda_oe); // R10
endmodule

bind i2c_ctl_seq i2c_ctl_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .en           (en),
  .sto          (sto),
  .si           (si),
  .aa           (aa),
  .own_addr_hit (own_addr_hit),
  .gcall_hit    (gcall_hit),
  .gcall_en     (gcall_en),
  .mrx_data     (mrx_data),
  .srx_data     (srx_data),
  .ack_take     (ack_take),
  .seq_done     (seq_done),
  .stop_done    (stop_done),
  .busy         (busy),
  .sda_oe       (sda_oe),
  .scl_oe       (scl_oe)
);

// File: tb/i2c_ctl_seq_tb.sv
module i2c_ctl_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       bus_master = 1'b0;
  logic       own_addr_hit = 1'b0, gcall_hit = 1'b0, gcall_en = 1'b0;
  logic       mrx_data = 1'b0, srx_data = 1'b0;
  logic       ack_slot = 1'b0;
  logic       bit_tick = 1'b0;
  logic       stretch = 1'b0;
  logic       scl_in;
  logic       sda_oe, scl_oe, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  assign scl_in = !scl_oe && !stretch;

  i2c_ctl_seq #(.SCL_SYNC(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .bus_master(bus_master), .own_addr_hit(own_addr_hit), .gcall_hit(gcall_hit),
    .gcall_en(gcall_en), .mrx_data(mrx_data), .srx_data(srx_data), .ack_slot(ack_slot),
    .bit_tick(bit_tick), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe), .irq(irq)
  );

  // Tick every fourth cycle.
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt     <= (tcnt + 1) % 4;
    bit_tick <= (tcnt == 3);
  end

  // Line-step monitor: records each change of {sda_oe, scl_oe}.
  logic [1:0] lg [0:1023];
  int         log_n = 0;
  logic [1:0] prev = 2'b00;
  always @(negedge clk) begin
    if (rst_n && ({sda_oe, scl_oe} != prev)) begin
      lg[log_n % 1024] <= {sda_oe, scl_oe};
      log_n <= log_n + 1;
      prev  <= {sda_oe, scl_oe};
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // exp holds entry i at bits [2*i+:2]; reported values carry the entry count above bit 12.
  task automatic chk_log(input string req, input int base, input int n, input logic [11:0] exp);
    int         cnt;
    logic [11:0] act;
    cnt = log_n - base;
    act = '0;
    for (int i = 0; i < 6; i++) if (i < cnt) act[2*i+:2] = lg[(base + i) % 1024];
    chk((cnt == n) && (act == exp), req, {cnt[15:0], 4'h0, act}, {n[15:0], 4'h0, exp});
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack_slot = 1'b1;
    @(negedge clk); ack_slot = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int base;
    idle(3);
    // R1 reset state
    chk(rd_data == 8'h00, "R1 reg", rd_data, 8'h00);
    chk({sda_oe, scl_oe, irq} == 3'b000, "R1 lines", {sda_oe, scl_oe, irq}, 3'b000);
    rst_n = 1'b1;
    idle(3);

    // R2 layout and reserved bits
    wr(8'h86); idle(1);
    chk(rd_data == 8'h04, "R2 reserved", rd_data, 8'h04);
    wr(8'h03); idle(1);
    chk(rd_data == 8'h01, "R2 clock-select", rd_data, 8'h01);

    // R12 disabled: commands and ack requests have no effect
    base = log_n;
    wr(8'h34); idle(80);
    chk_log("R12 cmd", base, 0, 12'h000);
    chk(rd_data == 8'h34, "R12 reg", rd_data, 8'h34);
    pulse_ack(); idle(40);
    chk_log("R12 ack", base, 0, 12'h000);
    wr(8'h00); idle(2);

    // R4 START as non-master
    bus_master = 1'b0;
    base = log_n;
    wr(8'h60); idle(80);
    chk_log("R4 steps", base, 3, {2'b01, 2'b11, 2'b10});
    chk(rd_data == 8'h68, "R4 reg", rd_data, 8'h68);
    chk(irq == 1'b1, "R3 irq", irq, 1'b1);

    // R11 hold while flag set; ack request not started
    base = log_n;
    pulse_ack(); idle(60);
    chk_log("R11 no start", base, 0, 12'h000);
    chk(scl_oe == 1'b1, "R11 scl held", scl_oe, 1'b1);
    wr(8'h40); idle(10);

    // R3 writing 1 to the flag does nothing
    wr(8'h48); idle(2);
    chk(rd_data == 8'h40, "R3 write one", rd_data, 8'h40);

    // R5 repeated START as master
    bus_master = 1'b1;
    base = log_n;
    wr(8'h60); idle(80);
    chk_log("R5 steps", base, 5, {2'b01, 2'b11, 2'b10, 2'b00, 2'b01});
    chk(rd_data == 8'h68, "R5 reg", rd_data, 8'h68);
    wr(8'h40); idle(10);

    // R6 STOP as master
    base = log_n;
    wr(8'h50); idle(80);
    chk_log("R6 steps", base, 3, {2'b00, 2'b10, 2'b11});
    chk(rd_data == 8'h40, "R6 reg", rd_data, 8'h40);

    // R7 STOP then START as master
    base = log_n;
    wr(8'h70); idle(100);
    chk_log("R7 steps", base, 6, {2'b01, 2'b11, 2'b10, 2'b00, 2'b10, 2'b11});
    chk(rd_data == 8'h68, "R7 reg", rd_data, 8'h68);
    wr(8'h40); idle(10);

    // R8 STOP as slave: internal only
    bus_master = 1'b0;
    base = log_n;
    wr(8'h50); idle(60);
    chk_log("R8 stop", base, 0, 12'h000);
    chk(rd_data == 8'h40, "R8 reg", rd_data, 8'h40);
    base = log_n;
    wr(8'h70); idle(80);
    chk_log("R8 stop start", base, 3, {2'b01, 2'b11, 2'b10});
    chk(rd_data == 8'h68, "R8 reg2", rd_data, 8'h68);
    wr(8'h40); idle(10);

    // R9 / R10 exhaustive acknowledge sweep
    for (int k = 0; k < 64; k++) begin
      logic a_en, e_ack;
      logic [7:0] ctl;
      a_en = k[5];
      ctl  = 8'h40 | (8'(a_en) << 2);
      wr(ctl); idle(4);
      own_addr_hit = k[0]; gcall_hit = k[1]; gcall_en = k[2]; mrx_data = k[3]; srx_data = k[4];
      e_ack = a_en && (k[0] || (k[1] && k[2]) || k[3] || k[4]);
      base = log_n;
      pulse_ack(); idle(60);
      if (e_ack) chk_log("R9 ack", base, 4, {2'b01, 2'b11, 2'b10, 2'b11});
      else       chk_log("R10 nack", base, 3, {2'b01, 2'b00, 2'b01});
      chk(rd_data == (ctl | 8'h08), "R9 R10 flag", rd_data, ctl | 8'h08);
      wr(ctl); idle(6);
    end
    own_addr_hit = 0; gcall_hit = 0; gcall_en = 0; mrx_data = 0; srx_data = 0;
    wr(8'h40); idle(6);

    // R13 clock stretching holds the START
    stretch = 1'b1;
    base = log_n;
    wr(8'h60); idle(80);
    chk_log("R13 waiting", base, 0, 12'h000);
    stretch = 1'b0;
    idle(80);
    chk_log("R13 resumed", base, 3, {2'b01, 2'b11, 2'b10});

    // R12 disable while flag set releases lines; R11 hold returns on enable
    wr(8'h28); idle(2);
    chk({sda_oe, scl_oe, irq} == 3'b001, "R12 released", {sda_oe, scl_oe, irq}, 3'b001);
    wr(8'h48); idle(2);
    chk(scl_oe == 1'b1, "R11 re-enable", scl_oe, 1'b1);
    wr(8'h40); idle(4);
    chk(scl_oe == 1'b0, "R3 clear", scl_oe, 1'b0);

    report();
    $finish;
  end
endmodule